// File: doc/BRIEF.md
# Predicate Shadow Release Manager

This block sits between vector issue and a small pool of function units. Each vector element is issued to a unit speculatively and stays under that unit's shadow. The predicate mask comes from a scalar integer register and can arrive before or after the elements are issued. While it is outstanding, every shadow stays held. Once the mask is captured, a manager outside the arithmetic units splits it into per-element bits. It then pulses proceed or cancel on each shadowed unit in the same cycle. A unit that is allowed to proceed waits for its operand, requests write permission, and commits its element when the grant arrives. The operation modelled is a copy: destination element i takes source element i. A cancelled unit drops its work and is free again on the next cycle.

A mask equal to 1<<n therefore writes element n alone, which is the same as an indexed single-element move. An element may also be issued with a condition-register predicate bit. That bit bypasses the manager and acts directly as the unit's result-write mask. A vector-length change stalls issue until the new length is supplied. Elements whose index is at or above the current length are always cancelled.

State machines and their transitions:
- Each function unit steps FU_IDLE → FU_WAIT_OP on issue, FU_WAIT_OP → FU_HOLD on operand delivery, and FU_HOLD → FU_IDLE on a granted write or a masked-off result. It goes from FU_WAIT_OP or FU_HOLD → FU_IDLE on cancel.
- Issue control steps CT_RUN → CT_VL_STALL on a length change and CT_VL_STALL → CT_RUN when the new length is supplied.
- Mask capture steps MK_PENDING → MK_KNOWN when the mask is supplied and MK_KNOWN → MK_PENDING when a new operation starts.

Top module: `pred_shadow_mgr`

## Requirements
- R1: After reset all units are idle, no proceed, cancel, write request or write is asserted, issue is ready, the mask is pending and the vector length reads 24.
- R2: While the mask is pending (after `op_start` and before `mask_valid`), no proceed or cancel is asserted for any unit.
- R3: In the cycle after the mask is captured, or in the cycle after issue if the mask is already known, every shadowed unit whose element index e is below the length and has mask bit e set gets a one-cycle proceed pulse.
- R4: A shadowed unit whose element's mask bit is 0 gets a one-cycle cancel pulse and returns to idle with no write.
- R5: An element whose index is greater than or equal to the current length is cancelled whatever its mask bit.
- R6: Proceed and cancel are never asserted together on a unit, and each issued element is resolved at most once.
- R7: A unit raises its write request only after it has received its operand and its shadow has been released.
- R8: A write request is held until `fu_wr_grant` for that unit is 1. The write then happens in that cycle with `fu_wr_el` equal to the issued index and `fu_wr_data` equal to the delivered source operand.
- R9: A mask of 1<<n writes only element n and cancels every other shadowed element.
- R10: An element issued with `issue_cr_en`=1 is never shadowed. With `issue_cr_bit`=1 it is written once its operand arrives, even while the mask is pending. With `issue_cr_bit`=0 it goes idle without writing.
- R11: From the cycle after `vl_change` until the edge that samples `vl_valid`, `issue_ready` is 0. After that edge, `vl_cur` equals `vl_value`.
- R12: A unit that was cancelled is idle on the next cycle and accepts a new issue there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | New vector operation; mask becomes pending |
| mask_valid | input | 1 | Scalar predicate mask is available |
| mask_value | input | MAX_EL | Predicate mask, bit e for element e |
| vl_change | input | 1 | Vector length is about to change |
| vl_valid | input | 1 | New vector length is supplied |
| vl_value | input | EW | New vector length |
| issue_valid | input | 1 | Issue an element |
| issue_fu | input | FU_W | Target function unit |
| issue_el | input | EW | Element index |
| issue_cr_en | input | 1 | Element uses a condition-register predicate bit |
| issue_cr_bit | input | 1 | Condition-register predicate bit |
| issue_ready | output | 1 | Issue accepted this cycle |
| fu_op_valid | input | N_FU | Operand delivered to unit |
| fu_op_data | input | N_FU*DW | Source operands, unit i at bits i*DW |
| fu_proceed | output | N_FU | Shadow proceed pulse per unit |
| fu_cancel | output | N_FU | Shadow cancel pulse per unit |
| fu_busy | output | N_FU | Unit holds an element |
| fu_wr_req | output | N_FU | Unit asks for write permission |
| fu_wr_grant | input | N_FU | Write permission per unit |
| fu_wr_en | output | N_FU | Destination write this cycle |
| fu_wr_el | output | N_FU*EW | Destination element index per unit |
| fu_wr_data | output | N_FU*DW | Destination data per unit |
| vl_cur | output | EW | Current vector length |

## Verification
The mask is registered, so proceed and cancel appear combinationally in the cycle after the capture edge. The bench samples them on the falling edge right after the stimulus task returns. Write requests and writes follow one edge after the release, once the operand has been delivered. A scoreboard queue holds the expected element and data, and a monitor compares them on every falling edge where a write enable is high. The stall is checked on the falling edge after the `vl_change` edge. The new length and renewed readiness are checked on the falling edge after the `vl_valid` edge.

// File: rtl/psm_pkg.sv
package psm_pkg;
    typedef enum logic [1:0] {FU_IDLE, FU_WAIT_OP, FU_HOLD} fu_state_e;
    typedef enum logic {CT_RUN, CT_VL_STALL} ctl_state_e;
    typedef enum logic {MK_PENDING, MK_KNOWN} mask_state_e;
endpackage

// File: rtl/psm_ctrl.sv
module psm_ctrl
    import psm_pkg::*;
#(
    parameter int MAX_EL = 24,
    parameter int EW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              mask_valid,
    input  logic [MAX_EL-1:0] mask_value,
    input  logic              vl_change,
    input  logic              vl_valid,
    input  logic [EW-1:0]     vl_value,
    output logic              run,
    output logic              mask_known,
    output logic [MAX_EL-1:0] mask_q,
    output logic [EW-1:0]     vl_q
);
    localparam logic [EW-1:0] VL_RST = EW'(MAX_EL);

    ctl_state_e  ct_state, ct_next;
    mask_state_e mk_state, mk_next;
    logic [MAX_EL-1:0] mask_n;
    logic [EW-1:0]     vl_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_state <= CT_RUN;
            mk_state <= MK_PENDING;
            mask_q   <= '0;
            vl_q     <= VL_RST;
        end else begin
            ct_state <= ct_next;
            mk_state <= mk_next;
            mask_q   <= mask_n;
            vl_q     <= vl_n;
        end
    end

    always_comb begin
        ct_next = ct_state;
        vl_n    = vl_q;
        unique case (ct_state)
            CT_RUN:      if (vl_change) ct_next = CT_VL_STALL;
            CT_VL_STALL: if (vl_valid) begin
                ct_next = CT_RUN;
                vl_n    = vl_value;
            end
            default:     ct_next = CT_RUN;
        endcase
    end

    always_comb begin
        mk_next = mk_state;
        mask_n  = mask_q;
        if (mask_valid) begin
            mk_next = MK_KNOWN;
            mask_n  = mask_value;
        end else begin
            unique case (mk_state)
                MK_PENDING: mk_next = MK_PENDING;
                MK_KNOWN:   if (op_start) mk_next = MK_PENDING;
                default:    mk_next = MK_PENDING;
            endcase
        end
    end

    assign run        = (ct_state == CT_RUN);
    assign mask_known = (mk_state == MK_KNOWN);
endmodule

// File: rtl/psm_fu.sv
module psm_fu
    import psm_pkg::*;
#(
    parameter int EW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [EW-1:0] issue_el,
    input  logic          cr_en,
    input  logic          cr_bit,
    input  logic          op_valid,
    input  logic [DW-1:0] op_data,
    input  logic          proceed,
    input  logic          cancel,
    input  logic          wr_grant,
    output logic          busy,
    output logic          shadowed,
    output logic [EW-1:0] el_q,
    output logic          wr_req,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);
    fu_state_e     state, state_n;
    logic [EW-1:0] el_n;
    logic [DW-1:0] data_q, data_n;
    logic          shadow_q, shadow_n;
    logic          wmask_q, wmask_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FU_IDLE;
            el_q     <= '0;
            data_q   <= '0;
            shadow_q <= 1'b0;
            wmask_q  <= 1'b0;
        end else begin
            state    <= state_n;
            el_q     <= el_n;
            data_q   <= data_n;
            shadow_q <= shadow_n;
            wmask_q  <= wmask_n;
        end
    end

    always_comb begin
        state_n  = state;
        el_n     = el_q;
        data_n   = data_q;
        shadow_n = shadow_q;
        wmask_n  = wmask_q;
        unique case (state)
            FU_IDLE: if (issue) begin
                state_n  = FU_WAIT_OP;
                el_n     = issue_el;
                shadow_n = !cr_en;
                wmask_n  = !cr_en || cr_bit;
            end
            FU_WAIT_OP: if (cancel) begin
                state_n  = FU_IDLE;
                shadow_n = 1'b0;
            end else begin
                if (proceed) shadow_n = 1'b0;
                if (op_valid) begin
                    state_n = FU_HOLD;
                    data_n  = op_data;
                end
            end
            FU_HOLD: if (cancel) begin
                state_n  = FU_IDLE;
                shadow_n = 1'b0;
            end else if (proceed) begin
                shadow_n = 1'b0;
            end else if (!shadow_q && (!wmask_q || wr_grant)) begin
                state_n = FU_IDLE;
            end
            default: state_n = FU_IDLE;
        endcase
    end

    assign busy     = (state != FU_IDLE);
    assign shadowed = shadow_q;
    assign wr_req   = (state == FU_HOLD) && !shadow_q && wmask_q;
    assign wr_en    = wr_req && wr_grant;
    assign wr_data  = data_q;
endmodule

// File: rtl/pred_shadow_mgr.sv
module pred_shadow_mgr
    import psm_pkg::*;
#(
    parameter int N_FU   = 4,
    parameter int MAX_EL = 24,
    parameter int DW     = 16,
    parameter int EW     = $clog2(MAX_EL + 1),
    parameter int FU_W   = (N_FU > 1) ? $clog2(N_FU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 mask_valid,
    input  logic [MAX_EL-1:0]    mask_value,
    input  logic                 vl_change,
    input  logic                 vl_valid,
    input  logic [EW-1:0]        vl_value,
    input  logic                 issue_valid,
    input  logic [FU_W-1:0]      issue_fu,
    input  logic [EW-1:0]        issue_el,
    input  logic                 issue_cr_en,
    input  logic                 issue_cr_bit,
    output logic                 issue_ready,
    input  logic [N_FU-1:0]      fu_op_valid,
    input  logic [N_FU*DW-1:0]   fu_op_data,
    output logic [N_FU-1:0]      fu_proceed,
    output logic [N_FU-1:0]      fu_cancel,
    output logic [N_FU-1:0]      fu_busy,
    output logic [N_FU-1:0]      fu_wr_req,
    input  logic [N_FU-1:0]      fu_wr_grant,
    output logic [N_FU-1:0]      fu_wr_en,
    output logic [N_FU*EW-1:0]   fu_wr_el,
    output logic [N_FU*DW-1:0]   fu_wr_data,
    output logic [EW-1:0]        vl_cur
);
    logic              run_w;
    logic              mask_known_w;
    logic [MAX_EL-1:0] mask_w;
    logic [EW-1:0]     vl_w;
    logic [N_FU-1:0]   shadowed_w;
    logic              accept;

    psm_ctrl #(.MAX_EL(MAX_EL), .EW(EW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_start(op_start),
        .mask_valid(mask_valid), .mask_value(mask_value),
        .vl_change(vl_change), .vl_valid(vl_valid), .vl_value(vl_value),
        .run(run_w), .mask_known(mask_known_w), .mask_q(mask_w), .vl_q(vl_w)
    );

    assign issue_ready = run_w && !fu_busy[issue_fu];
    assign accept      = issue_valid && issue_ready;
    assign vl_cur      = vl_w;

    for (genvar i = 0; i < N_FU; i++) begin : g_fu
        logic [EW-1:0] el_i;
        logic          bit_on;

        psm_fu #(.EW(EW), .DW(DW)) u_fu (
            .clk(clk), .rst_n(rst_n),
            .issue(accept && (issue_fu == FU_W'(i))),
            .issue_el(issue_el), .cr_en(issue_cr_en), .cr_bit(issue_cr_bit),
            .op_valid(fu_op_valid[i]), .op_data(fu_op_data[i*DW +: DW]),
            .proceed(fu_proceed[i]), .cancel(fu_cancel[i]),
            .wr_grant(fu_wr_grant[i]),
            .busy(fu_busy[i]), .shadowed(shadowed_w[i]), .el_q(el_i),
            .wr_req(fu_wr_req[i]), .wr_en(fu_wr_en[i]),
            .wr_data(fu_wr_data[i*DW +: DW])
        );

        // Element is live only inside the vector length and with its mask bit set.
        assign bit_on = (el_i < vl_w) && (el_i < EW'(MAX_EL)) && mask_w[el_i];
        assign fu_proceed[i] = shadowed_w[i] && mask_known_w && bit_on;
        assign fu_cancel[i]  = shadowed_w[i] && mask_known_w && !bit_on;
        assign fu_wr_el[i*EW +: EW] = el_i;
    end
endmodule

// File: rtl/psm_chk.sv
module psm_chk #(
    parameter int N_FU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_FU-1:0] fu_proceed,
    input logic [N_FU-1:0] fu_cancel,
    input logic [N_FU-1:0] fu_busy,
    input logic [N_FU-1:0] fu_wr_req,
    input logic [N_FU-1:0] fu_wr_grant,
    input logic            issue_ready,
    input logic            ctl_run,
    input logic            mask_known
);
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_known |-> (fu_proceed == '0 && fu_cancel == '0));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_proceed & fu_cancel) == '0);

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_run |-> !issue_ready);

    for (genvar i = 0; i < N_FU; i++) begin : g_u
        p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (fu_proceed[i] || fu_cancel[i]) |=> !(fu_proceed[i] || fu_cancel[i]));

        p_cancel_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
            fu_cancel[i] |=> !fu_busy[i]);

        p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (fu_wr_req[i] && !fu_wr_grant[i]) |=> fu_wr_req[i]);

        p_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fu_wr_req[i] |-> fu_busy[i]);
    end
endmodule

bind pred_shadow_mgr psm_chk #(.N_FU(N_FU)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fu_proceed(fu_proceed), .fu_cancel(fu_cancel), .fu_busy(fu_busy),
    .fu_wr_req(fu_wr_req), .fu_wr_grant(fu_wr_grant),
    .issue_ready(issue_ready), .ctl_run(run_w), .mask_known(mask_known_w)
);

// File: tb/sim_pred_shadow_mgr.sv
`timescale 1ns/1ps
module sim_pred_shadow_mgr;
    localparam int N  = 4;
    localparam int ME = 24;
    localparam int DW = 16;
    localparam int EW = 5;
    localparam int FW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, mask_valid = 1'b0, vl_change = 1'b0, vl_valid = 1'b0;
    logic [ME-1:0] mask_value = '0;
    logic [EW-1:0] vl_value = '0;
    logic issue_valid = 1'b0, issue_cr_en = 1'b0, issue_cr_bit = 1'b0;
    logic [FW-1:0] issue_fu = '0;
    logic [EW-1:0] issue_el = '0;
    logic issue_ready;
    logic [N-1:0] op_valid = '0;
    logic [N*DW-1:0] op_data = '0;
    logic [N-1:0] proceed, cancel, busy, wr_req, wr_en;
    logic [N-1:0] grant = '1;
    logic [N*EW-1:0] wr_el;
    logic [N*DW-1:0] wr_data;
    logic [EW-1:0] vl_cur;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [EW+DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    pred_shadow_mgr u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start),
        .mask_valid(mask_valid), .mask_value(mask_value),
        .vl_change(vl_change), .vl_valid(vl_valid), .vl_value(vl_value),
        .issue_valid(issue_valid), .issue_fu(issue_fu), .issue_el(issue_el),
        .issue_cr_en(issue_cr_en), .issue_cr_bit(issue_cr_bit),
        .issue_ready(issue_ready), .fu_op_valid(op_valid), .fu_op_data(op_data),
        .fu_proceed(proceed), .fu_cancel(cancel), .fu_busy(busy),
        .fu_wr_req(wr_req), .fu_wr_grant(grant), .fu_wr_en(wr_en),
        .fu_wr_el(wr_el), .fu_wr_data(wr_data), .vl_cur(vl_cur)
    );

    function automatic logic [DW-1:0] pat(input int el);
        return DW'(16'hA000 + el * 17);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_exp(input int el);
        exp_q.push_back({EW'(el), pat(el)});
    endtask

    task automatic do_issue(input int fu, input int el, input bit cre, input bit crb);
        issue_fu = FW'(fu); issue_el = EW'(el);
        issue_cr_en = cre; issue_cr_bit = crb; issue_valid = 1'b1;
        step();
        issue_valid = 1'b0; issue_cr_en = 1'b0; issue_cr_bit = 1'b0; issue_fu = '0;
    endtask

    task automatic do_operand(input int fu, input int el);
        op_valid[fu] = 1'b1;
        op_data[fu*DW +: DW] = pat(el);
        step();
        op_valid = '0;
    endtask

    task automatic do_mask(input logic [ME-1:0] m);
        mask_value = m; mask_valid = 1'b1;
        step();
        mask_valid = 1'b0;
    endtask

    task automatic do_start();
        op_start = 1'b1;
        step();
        op_start = 1'b0;
    endtask

    task automatic do_vl(input int v);
        vl_change = 1'b1;
        step();
        vl_change = 1'b0;
        @(negedge clk);
        chk(issue_ready == 1'b0, "R11 stall after change", issue_ready, 0);
        step();
        @(negedge clk);
        chk(issue_ready == 1'b0, "R11 stall held", issue_ready, 0);
        step();
        vl_value = EW'(v); vl_valid = 1'b1;
        step();
        vl_valid = 1'b0;
        @(negedge clk);
        chk(issue_ready == 1'b1, "R11 ready after length", issue_ready, 1);
        chk(vl_cur == EW'(v), "R11 new length", vl_cur, v);
        step();
    endtask

    // Monitor: compares every write against the scoreboard front.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (wr_en[i]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected write", {wr_el[i*EW +: EW], wr_data[i*DW +: DW]}, 0);
                    end else begin
                        logic [EW+DW-1:0] e;
                        e = exp_q.pop_front();
                        chk({wr_el[i*EW +: EW], wr_data[i*DW +: DW]} == e,
                            "R8 write element/data", {wr_el[i*EW +: EW], wr_data[i*DW +: DW]}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == '0, "R1 busy", busy, 0);
        chk(proceed == '0 && cancel == '0, "R1 shadows", {proceed, cancel}, 0);
        chk(wr_req == '0 && wr_en == '0, "R1 writes", {wr_req, wr_en}, 0);
        chk(issue_ready == 1'b1, "R1 ready", issue_ready, 1);
        chk(vl_cur == 5'd24, "R1 length", vl_cur, 24);
        step();

        // R2 R3 R4 R7: four elements, mask arrives last
        do_start();
        for (int f = 0; f < 4; f++) do_issue(f, f, 1'b0, 1'b0);
        for (int f = 0; f < 4; f++) do_operand(f, f);
        @(negedge clk);
        chk(proceed == '0 && cancel == '0, "R2 held while pending", {proceed, cancel}, 0);
        chk(wr_req == '0, "R7 no request under shadow", wr_req, 0);
        push_exp(0); push_exp(2);
        do_mask(24'h000005);
        @(negedge clk);
        chk(proceed == 4'b0101, "R3 proceed lines", proceed, 4'b0101);
        chk(cancel == 4'b1010, "R4 cancel lines", cancel, 4'b1010);
        step();
        @(negedge clk);
        chk(busy == 4'b0101, "R4 R12 cancelled units idle", busy, 4'b0101);
        chk(proceed == '0 && cancel == '0, "R6 single pulse", {proceed, cancel}, 0);
        step();
        @(negedge clk);
        chk(busy == '0, "R8 units idle after write", busy, 0);

        // R11 then R5: length 2
        do_vl(2);
        do_start();
        do_issue(0, 1, 1'b0, 1'b0);
        do_issue(1, 3, 1'b0, 1'b0);
        do_operand(0, 1);
        do_operand(1, 3);
        push_exp(1);
        do_mask(24'hFFFFFF);
        @(negedge clk);
        chk(proceed == 4'b0001, "R5 inside length proceeds", proceed, 4'b0001);
        chk(cancel == 4'b0010, "R5 beyond length cancelled", cancel, 4'b0010);
        step(); step();

        // R9: single-bit mask acts as an indexed move
        do_vl(24);
        do_start();
        for (int f = 0; f < 4; f++) do_issue(f, f + 5, 1'b0, 1'b0);
        for (int f = 0; f < 4; f++) do_operand(f, f + 5);
        push_exp(7);
        do_mask(24'h1 << 7);
        @(negedge clk);
        chk(proceed == 4'b0100, "R9 only element 7 proceeds", proceed, 4'b0100);
        chk(cancel == 4'b1011, "R9 others cancelled", cancel, 4'b1011);
        step(); step();

        // R8: write held until grant
        grant = 4'b1110;
        do_start();
        do_issue(0, 9, 1'b0, 1'b0);
        do_operand(0, 9);
        push_exp(9);
        do_mask(24'h1 << 9);
        @(negedge clk);
        chk(proceed == 4'b0001, "R3 proceed el9", proceed, 4'b0001);
        step();
        @(negedge clk);
        chk(wr_req[0] == 1'b1 && wr_en[0] == 1'b0, "R8 request waits", {wr_req[0], wr_en[0]}, 2'b10);
        step(); step(); step();
        @(negedge clk);
        chk(wr_req[0] == 1'b1 && wr_en[0] == 1'b0, "R8 request still held", {wr_req[0], wr_en[0]}, 2'b10);
        step();
        grant = '1;
        step();
        @(negedge clk);
        chk(busy == '0, "R8 idle after granted write", busy, 0);

        // R10: condition-register bypass
        do_start();
        do_issue(1, 4, 1'b1, 1'b1);
        do_issue(2, 6, 1'b1, 1'b0);
        push_exp(4);
        op_valid = 4'b0110;
        op_data[1*DW +: DW] = pat(4);
        op_data[2*DW +: DW] = pat(6);
        step();
        op_valid = '0;
        @(negedge clk);
        chk(wr_req == 4'b0010, "R10 bypass writes without mask", wr_req, 4'b0010);
        chk(proceed == '0 && cancel == '0, "R10 no shadow lines", {proceed, cancel}, 0);
        step();
        @(negedge clk);
        chk(busy == '0, "R10 masked-off unit idle without write", busy, 0);

        // R12: cancel before operand, immediate reuse; R3 with mask already known
        do_start();
        do_mask(24'h1 << 11);
        do_issue(3, 10, 1'b0, 1'b0);
        @(negedge clk);
        chk(cancel == 4'b1000, "R4 cancel before operand", cancel, 4'b1000);
        step();
        issue_fu = 2'd3;
        @(negedge clk);
        chk(busy[3] == 1'b0 && issue_ready == 1'b1, "R12 reusable next cycle", {busy[3], issue_ready}, 1);
        step();
        do_issue(3, 11, 1'b0, 1'b0);
        @(negedge clk);
        chk(proceed == 4'b1000, "R3 proceed with known mask", proceed, 4'b1000);
        push_exp(11);
        do_operand(3, 11);
        step(); step();

        repeat (4) step();
        chk(exp_q.size() == 0, "R8 all expected writes seen", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule